// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block is the bus-side front end of a small NOR-style flash model. It observes host write cycles and recognises the multi-write command sequences that unlock the part and then select identification reads, a program, or a full-array erase. It keeps track of whether host reads return stored array contents or identification codes. It hands accepted program and erase jobs to a separate embedded-operation sequencer. While such a job is outstanding, the block shuts out every bus write.

Host writes use a plain strobe, because a bus write cycle cannot be refused. Host reads use a request stream and a response stream, both valid/ready. A request is taken on any edge where `rq_valid` and `rq_ready` are both high. `rq_ready` is high while no response is waiting, or while the waiting response is being taken in the same cycle. A response holds its data unchanged until `rs_ready` is high.

The job hand-off to the sequencer also uses valid/ready. The job fields stay constant until they are accepted. The sequencer reports the end of a job with a single-cycle `op_done` pulse. The array storage is external and is read combinationally through `arr_addr` and `arr_rdata`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `busy`, `op_valid` and `rs_valid` are 0, `rq_ready` is 1, and reads return array data.
- R2: The two unlock writes depend on the mode. In word mode (`byte_mode`=0) they are data low byte AAh at address low 11 bits 555h, then 55h at low 11 bits 2AAh. In byte mode they are AAh at address low 12 bits AAAh, then 55h at low 12 bits 555h. The address of the command write that follows is not checked. Command 90h after the unlocks enters identification mode.
- R3: Identification reads decode only the low 8 address bits. In word mode, 00h returns the manufacturer code (default 0001h) and 01h returns the device code (default 2257h). In byte mode, 00h returns 01h and 02h returns the device code's low byte 57h. Any other offset returns 0.
- R4: An identification read at offset 02h (word mode) or 04h (byte mode) returns 1 if the addressed sector is protected and 0 if it is not. The sector is the top 3 bits of the 17-bit word address. In byte mode the word address is the byte address shifted right by one. `sect_prot` bit n marks sector n.
- R5: Identification mode persists across any number of reads. A write of F0h, or any other write that does not start an unlock, returns the block to array reads.
- R6: Two unlocks, then A0h, then one more write launches a program job on the edge of that last write. `op_valid`=1, `op_erase`=0, and `op_addr` and `op_data` equal that write's address and data.
- R7: Two unlocks, 80h, two more unlocks, then 10h launches a chip-erase job with `op_valid`=1 and `op_erase`=1. Five of the six writes alone launch nothing.
- R8: A write that breaks a sequence at any step abandons the partial sequence, launches nothing and returns to array reads.
- R9: `busy` is high from launch until `op_done`. The job fields stay stable until `op_ready`. All writes in that window are ignored, so neither the read mode nor the sequence state changes.
- R10: Reset clears any job in progress and returns the block to array reads.
- R11: A response waits with stable data while `rs_ready` is low, and `rq_ready` stays low meanwhile. The data reflects the read mode at the edge where the request was accepted.
- R12: Array reads drive `arr_addr` with the word address. Word mode returns all 16 bits of `arr_rdata`. Byte mode returns the low byte for an even byte address and the high byte for an odd one, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, aborts any job |
| byte_mode | input | 1 | 1 = byte-wide bus, 0 = word-wide bus |
| sect_prot | input | 8 | Static per-sector protection flags |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 18 | Host write address |
| wr_data | input | 16 | Host write data |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request accepted |
| rq_addr | input | 18 | Read address |
| rs_valid | output | 1 | Read response valid |
| rs_ready | input | 1 | Read response taken |
| rs_data | output | 16 | Read response data |
| arr_addr | output | 17 | Array word address |
| arr_rdata | input | 16 | Array word at `arr_addr` |
| op_valid | output | 1 | Job offered to the sequencer |
| op_ready | input | 1 | Sequencer takes the job |
| op_erase | output | 1 | 1 = chip erase, 0 = program |
| op_addr | output | 18 | Program address |
| op_data | output | 16 | Program data |
| op_done | input | 1 | Job finished pulse |
| busy | output | 1 | Job outstanding, writes locked out |

## Verification
If the sequence state is wrong, the fault appears as a job launched or missed on the edge of the final write. `op_valid` shows it one cycle later, at the first point where it can be observed. If the read mode is wrong, it stays hidden until the next read, whose response comes out one cycle after acceptance with array data where an identification code was expected, or the reverse. A leak in the write lockout is the slowest fault to appear. It shows only after `op_done`, when the next read reveals a mode that a write during the job should not have been able to change.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UL1, SQ_UL2, SQ_PSET, SQ_EUL0, SQ_EUL1, SQ_EUL2
  } sq_t;

  typedef enum logic [1:0] {HO_OFF, HO_REQ, HO_RUN} ho_t;

  localparam logic [7:0] C_UL1  = 8'hAA;
  localparam logic [7:0] C_UL2  = 8'h55;
  localparam logic [7:0] C_AUTO = 8'h90;
  localparam logic [7:0] C_PGM  = 8'hA0;
  localparam logic [7:0] C_ESET = 8'h80;
  localparam logic [7:0] C_CHIP = 8'h10;
  localparam logic [7:0] C_RST  = 8'hF0;

  // first unlock write: word bus 555h, byte bus AAAh
  function automatic logic hit_ul1(input logic [11:0] a, input logic [7:0] d,
                                   input logic bm);
    return (d == C_UL1) && (bm ? (a == 12'hAAA) : (a[10:0] == 11'h555));
  endfunction

  // second unlock write: word bus 2AAh, byte bus 555h
  function automatic logic hit_ul2(input logic [11:0] a, input logic [7:0] d,
                                   input logic bm);
    return (d == C_UL2) && (bm ? (a == 12'h555) : (a[10:0] == 11'h2AA));
  endfunction

endpackage

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [11:0] a12,
  input  logic [7:0]  d8,
  input  logic        byte_mode,
  input  logic        lockout,
  output logic        id_mode,
  output logic        launch_pgm,
  output logic        launch_ers
);
  sq_t  st, st_nx;
  logic idm_nx;
  logic take;

  assign take = wr_en & ~lockout;

  always_comb begin
    st_nx      = st;
    idm_nx     = id_mode;
    launch_pgm = 1'b0;
    launch_ers = 1'b0;
    if (take) begin
      st_nx = SQ_IDLE;
      case (st)
        SQ_IDLE: begin
          if (hit_ul1(a12, d8, byte_mode)) st_nx = SQ_UL1;
          else idm_nx = 1'b0;
        end
        SQ_UL1: begin
          if (hit_ul2(a12, d8, byte_mode)) st_nx = SQ_UL2;
          else idm_nx = 1'b0;
        end
        SQ_UL2: begin
          case (d8)
            C_AUTO: idm_nx = 1'b1;
            C_PGM:  st_nx  = SQ_PSET;
            C_ESET: st_nx  = SQ_EUL0;
            C_RST:  idm_nx = 1'b0;
            default: idm_nx = 1'b0;
          endcase
        end
        SQ_PSET: begin
          launch_pgm = 1'b1;
          idm_nx     = 1'b0;
        end
        SQ_EUL0: begin
          if (hit_ul1(a12, d8, byte_mode)) st_nx = SQ_EUL1;
          else idm_nx = 1'b0;
        end
        SQ_EUL1: begin
          if (hit_ul2(a12, d8, byte_mode)) st_nx = SQ_EUL2;
          else idm_nx = 1'b0;
        end
        SQ_EUL2: begin
          idm_nx = 1'b0;
          if (d8 == C_CHIP) launch_ers = 1'b1;
        end
        default: idm_nx = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      id_mode <= 1'b0;
    end else begin
      st      <= st_nx;
      id_mode <= idm_nx;
    end
  end
endmodule

// File: rtl/fcmd_handoff.sv
module fcmd_handoff
  import fcmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_pgm,
  input  logic              launch_ers,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_ready,
  input  logic              op_done,
  output logic              op_valid,
  output logic              op_erase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              busy
);
  ho_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= HO_OFF;
      op_erase <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      case (st)
        HO_OFF: if (launch_pgm || launch_ers) begin
          st       <= HO_REQ;
          op_erase <= launch_ers;
          op_addr  <= launch_pgm ? wr_addr : '0;
          op_data  <= launch_pgm ? wr_data : '0;
        end
        HO_REQ: if (op_ready) st <= HO_RUN;
        HO_RUN: if (op_done) st <= HO_OFF;
        default: st <= HO_OFF;
      endcase
    end
  end

  assign op_valid = (st == HO_REQ);
  assign busy     = (st != HO_OFF);
endmodule

// File: rtl/fcmd_rdpath.sv
module fcmd_rdpath #(
  parameter int          ADDR_W   = 18,
  parameter int          DATA_W   = 16,
  parameter int          NUM_SECT = 8,
  parameter logic [7:0]  MFR_ID   = 8'h01,
  parameter logic [15:0] DEV_ID   = 16'h2257,
  localparam int         WA_W     = ADDR_W - 1,
  localparam int         SECT_W   = $clog2(NUM_SECT),
  localparam int         HALF     = DATA_W / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                byte_mode,
  input  logic                id_mode,
  input  logic [NUM_SECT-1:0] sect_prot,
  input  logic                rq_valid,
  output logic                rq_ready,
  input  logic [ADDR_W-1:0]   rq_addr,
  output logic                rs_valid,
  input  logic                rs_ready,
  output logic [DATA_W-1:0]   rs_data,
  output logic [WA_W-1:0]     arr_addr,
  input  logic [DATA_W-1:0]   arr_rdata
);
  logic [SECT_W-1:0] sect;
  logic              prot;
  logic [7:0]        off;
  logic [DATA_W-1:0] id_val, arr_val;

  assign arr_addr = byte_mode ? rq_addr[ADDR_W-1:1] : rq_addr[WA_W-1:0];
  assign sect     = arr_addr[WA_W-1 -: SECT_W];
  assign prot     = sect_prot[sect];
  assign off      = rq_addr[7:0];

  always_comb begin
    id_val = '0;
    if (byte_mode) begin
      case (off)
        8'h00: id_val = DATA_W'(MFR_ID);
        8'h02: id_val = DATA_W'(DEV_ID[7:0]);
        8'h04: id_val = DATA_W'(prot);
        default: id_val = '0;
      endcase
    end else begin
      case (off)
        8'h00: id_val = DATA_W'(MFR_ID);
        8'h01: id_val = DATA_W'(DEV_ID);
        8'h02: id_val = DATA_W'(prot);
        default: id_val = '0;
      endcase
    end
  end

  always_comb begin
    if (!byte_mode)      arr_val = arr_rdata;
    else if (rq_addr[0]) arr_val = DATA_W'(arr_rdata[DATA_W-1:HALF]);
    else                 arr_val = DATA_W'(arr_rdata[HALF-1:0]);
  end

  assign rq_ready = !rs_valid || rs_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_data  <= '0;
    end else if (rq_valid && rq_ready) begin
      rs_valid <= 1'b1;
      rs_data  <= id_mode ? id_val : arr_val;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int          ADDR_W   = 18,
  parameter int          DATA_W   = 16,
  parameter int          NUM_SECT = 8,
  parameter logic [7:0]  MFR_ID   = 8'h01,
  parameter logic [15:0] DEV_ID   = 16'h2257,
  localparam int         WA_W     = ADDR_W - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                byte_mode,
  input  logic [NUM_SECT-1:0] sect_prot,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rq_valid,
  output logic                rq_ready,
  input  logic [ADDR_W-1:0]   rq_addr,
  output logic                rs_valid,
  input  logic                rs_ready,
  output logic [DATA_W-1:0]   rs_data,
  output logic [WA_W-1:0]     arr_addr,
  input  logic [DATA_W-1:0]   arr_rdata,
  output logic                op_valid,
  input  logic                op_ready,
  output logic                op_erase,
  output logic [ADDR_W-1:0]   op_addr,
  output logic [DATA_W-1:0]   op_data,
  input  logic                op_done,
  output logic                busy
);
  logic id_mode, launch_pgm, launch_ers;

  fcmd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .a12        (wr_addr[11:0]),
    .d8         (wr_data[7:0]),
    .byte_mode  (byte_mode),
    .lockout    (busy),
    .id_mode    (id_mode),
    .launch_pgm (launch_pgm),
    .launch_ers (launch_ers)
  );

  fcmd_handoff #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ho (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_pgm (launch_pgm),
    .launch_ers (launch_ers),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .op_ready   (op_ready),
    .op_done    (op_done),
    .op_valid   (op_valid),
    .op_erase   (op_erase),
    .op_addr    (op_addr),
    .op_data    (op_data),
    .busy       (busy)
  );

  fcmd_rdpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SECT(NUM_SECT),
    .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_mode (byte_mode),
    .id_mode   (id_mode),
    .sect_prot (sect_prot),
    .rq_valid  (rq_valid),
    .rq_ready  (rq_ready),
    .rq_addr   (rq_addr),
    .rs_valid  (rs_valid),
    .rs_ready  (rs_ready),
    .rs_data   (rs_data),
    .arr_addr  (arr_addr),
    .arr_rdata (arr_rdata)
  );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              busy,
  input logic              id_mode,
  input logic              op_valid,
  input logic              op_ready,
  input logic              op_erase,
  input logic [ADDR_W-1:0] op_addr,
  input logic [DATA_W-1:0] op_data,
  input logic              rq_valid,
  input logic              rq_ready,
  input logic              rs_valid,
  input logic              rs_ready,
  input logic [DATA_W-1:0] rs_data
);
  assert_job_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_addr) && $stable(op_data)
                              && $stable(op_erase));

  assert_busy_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  assert_busy_array_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !id_mode);

  assert_locked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en |=> $stable(id_mode));

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_data));

  assert_req_answered_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_ready |=> rs_valid);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .busy     (busy),
  .id_mode  (id_mode),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .op_erase (op_erase),
  .op_addr  (op_addr),
  .op_data  (op_data),
  .rq_valid (rq_valid),
  .rq_ready (rq_ready),
  .rs_valid (rs_valid),
  .rs_ready (rs_ready),
  .rs_data  (rs_data)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/100ps
module test_flash_cmd_decoder;
  logic        clk = 0, rst_n = 0, byte_mode = 0;
  logic [7:0]  sect_prot = 8'b0010_0100;
  logic        wr_en = 0;
  logic [17:0] wr_addr = '0, rq_addr = '0, op_addr;
  logic [15:0] wr_data = '0, rs_data, arr_rdata, op_data;
  logic        rq_valid = 0, rq_ready, rs_valid, rs_ready = 1;
  logic [16:0] arr_addr;
  logic        op_valid, op_ready = 0, op_erase, op_done = 0, busy;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [15:0] q_exp[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  assign arr_rdata = arr_addr[15:0] ^ 16'hA5C3;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .sect_prot(sect_prot),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_data(rs_data),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata),
    .op_valid(op_valid), .op_ready(op_ready), .op_erase(op_erase),
    .op_addr(op_addr), .op_data(op_data), .op_done(op_done), .busy(busy)
  );

  function automatic logic [15:0] exp_arr(logic [17:0] a, logic bm);
    logic [16:0] wa;
    logic [15:0] w;
    wa = bm ? a[17:1] : a[16:0];
    w  = wa[15:0] ^ 16'hA5C3;
    if (!bm) return w;
    return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // monitor: pops expected read data as responses are taken
  always @(negedge clk) begin
    #1;
    if (rst_n && rs_valid && rs_ready) begin
      if (q_exp.size() == 0) chk("R11 unexpected response", rs_data, 32'hX);
      else chk(q_tag.pop_front(), rs_data, q_exp.pop_front());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      nfail++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, 20000);
      summary();
    end
  end

  task automatic wr(logic [17:0] a, logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [17:0] a, logic [15:0] e, string tag);
    bit acc;
    q_exp.push_back(e); q_tag.push_back(tag);
    rq_valid = 1; rq_addr = a;
    do begin
      #1 acc = rq_ready;
      @(posedge clk); @(negedge clk);
    end while (!acc);
    rq_valid = 0;
  endtask

  task automatic unlock();
    if (byte_mode) begin wr(18'hAAA, 16'hAA); wr(18'h555, 16'h55); end
    else begin wr(18'h555, 16'hAA); wr(18'h2AA, 16'h55); end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(2);
    rst_n = 1;
    idle(1);
    chk("R1 busy", busy, 0);
    chk("R1 op_valid", op_valid, 0);
    chk("R1 rs_valid", rs_valid, 0);
    chk("R1 rq_ready", rq_ready, 1);
    rd(18'h00123, exp_arr(18'h00123, 0), "R1 R12 array word read");

    // word-mode identification
    unlock(); wr(18'h555, 16'h90);
    rd(18'h00000, 16'h0001, "R2 R3 manufacturer");
    rd(18'h00001, 16'h2257, "R3 device code");
    rd(18'h08002, 16'h0001, "R4 sector2 protected");
    rd(18'h04002, 16'h0000, "R4 sector1 open");
    rd(18'h3FF05, 16'h0000, "R3 other offset");
    rd(18'h00000, 16'h0001, "R5 still identification");
    wr(18'h00000, 16'hF0);
    rd(18'h00000, exp_arr(18'h0, 0), "R5 reset to array");

    // byte-mode identification and array
    byte_mode = 1;
    unlock(); wr(18'hAAA, 16'h90);
    rd(18'h00000, 16'h0001, "R2 R3 byte manufacturer");
    rd(18'h00002, 16'h0057, "R3 byte device code");
    rd(18'h28004, 16'h0001, "R4 byte sector5 protected");
    rd(18'h00001, 16'h0000, "R3 byte odd offset");
    wr(18'h00000, 16'hF0);
    rd(18'h00007, exp_arr(18'h7, 1), "R12 byte odd array");
    rd(18'h00006, exp_arr(18'h6, 1), "R12 byte even array");
    byte_mode = 0;

    // broken sequences
    unlock(); wr(18'h555, 16'h80); wr(18'h555, 16'hAA); wr(18'h123, 16'h55);
    wr(18'h555, 16'h10);
    chk("R8 broken erase op_valid", op_valid, 0);
    chk("R8 broken erase busy", busy, 0);
    unlock(); wr(18'h555, 16'h90);
    wr(18'h555, 16'hAA); wr(18'h555, 16'h55);
    rd(18'h00000, exp_arr(18'h0, 0), "R8 broken unlock leaves identification");

    // program launch and hand-off
    unlock(); wr(18'h555, 16'hA0); wr(18'h0ABCD, 16'h1234);
    chk("R6 op_valid", op_valid, 1);
    chk("R6 op_erase", op_erase, 0);
    chk("R6 op_addr", op_addr, 18'h0ABCD);
    chk("R6 op_data", op_data, 16'h1234);
    chk("R9 busy", busy, 1);
    unlock(); wr(18'h555, 16'h90);          // ignored: job pending
    chk("R9 held op_addr", op_addr, 18'h0ABCD);
    op_ready = 1; idle(1); op_ready = 0;
    chk("R9 taken op_valid", op_valid, 0);
    chk("R9 running busy", busy, 1);
    unlock(); wr(18'h555, 16'hA0); wr(18'h00010, 16'h00FF);  // ignored
    chk("R9 no relaunch", op_valid, 0);
    op_done = 1; idle(1); op_done = 0;
    chk("R9 done busy", busy, 0);
    chk("R9 done op_valid", op_valid, 0);
    rd(18'h00000, exp_arr(18'h0, 0), "R9 locked writes ignored");

    // chip erase
    unlock(); wr(18'h555, 16'h80); unlock();
    chk("R7 five writes no launch", op_valid, 0);
    wr(18'h555, 16'h10);
    chk("R7 erase op_valid", op_valid, 1);
    chk("R7 erase op_erase", op_erase, 1);

    // reset aborts
    rst_n = 0; idle(1); rst_n = 1; idle(1);
    chk("R10 busy cleared", busy, 0);
    chk("R10 op_valid cleared", op_valid, 0);
    unlock(); wr(18'h555, 16'h90);
    rst_n = 0; idle(1); rst_n = 1; idle(1);
    rd(18'h00000, exp_arr(18'h0, 0), "R10 reset to array");

    // back-pressure on responses
    unlock(); wr(18'h555, 16'h90);
    rs_ready = 0;
    rd(18'h00000, 16'h0001, "R11 mode at acceptance");
    wr(18'h00000, 16'hF0);
    idle(2);
    chk("R11 rs_valid held", rs_valid, 1);
    chk("R11 rq_ready low", rq_ready, 0);
    chk("R11 rs_data stable", rs_data, 16'h0001);
    rs_ready = 1;
    idle(1);
    rd(18'h00000, exp_arr(18'h0, 0), "R11 R5 array after release");
    idle(3);
    chk("R11 all responses seen", q_exp.size(), 0);
    summary();
  end
endmodule